// File: doc/BRIEF.md
# Multi-Core Doorbell Message Router

The router carries doorbell messages between a group of cores. A sender presents one message word for one cycle. The word holds a doorbell kind, a broadcast flag and a target tag. Every core the message addresses records it in one of two pending flags: a normal flag or a critical flag. The router then raises that core's interrupt request line.

Addressing works in one of two ways. With the broadcast flag set, every core is addressed. Otherwise, a core is addressed only when its programmable identity register equals the tag, so a tag can reach several cores or none. A core withdraws its own doorbell through a clear request. The clear request names the issuing core and a doorbell kind, and it touches only that core's flag of that kind. Kinds reserved for guest-level doorbells, and every other unassigned kind, are accepted silently and change nothing. Interrupt delivery and prioritisation belong to the consumer of the request lines.

Top module: `dbell_router`

## Requirements
- R1: Message word layout: bits [TAG_W-1:0] are the target tag, bit TAG_W is the broadcast flag, and bits [TAG_W+3:TAG_W+1] are the kind. Kind 0 selects the normal pending flag and kind 1 selects the critical pending flag.
- R2: A send of kind 2, 3 or 4 (the guest kinds) or of kind 5 to 7 changes no pending flag in any core.
- R3: A send with the broadcast flag set sets the selected flag in every core, whatever their identities.
- R4: A send with the broadcast flag clear sets the selected flag only in cores whose identity register equals the tag. This may be several cores or none.
- R5: `irq[i]` is high exactly when core i has its normal or its critical pending flag set.
- R6: A clear of kind 0 or 1 from source core s drops only core s's flag of that kind. Other cores and core s's other flag keep their values.
- R7: A clear of any kind other than 0 or 1 changes no flag.
- R8: When a send sets a flag and a clear drops the same flag in the same cycle, the flag ends up set.
- R9: Reset loads each identity register with its core index. A write on `id_we[i]` loads `id_wdata` into core i on the next edge. Later sends match against the new value, and `core_id` shows it.
- R10: Reset clears all pending flags. A set flag stays set across later sends until a clear of its kind from its own core arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snd_valid | input | 1 | Send request valid for this cycle |
| snd_msg | input | TAG_W+4 | Message word: kind, broadcast flag, tag |
| clr_valid | input | 1 | Clear request valid for this cycle |
| clr_src | input | max(1,clog2(NUM_CORES)) | Index of the core issuing the clear |
| clr_kind | input | 3 | Kind of flag to clear |
| id_we | input | NUM_CORES | Per-core identity write enable |
| id_wdata | input | TAG_W | Identity value to write |
| pend_norm | output | NUM_CORES | Normal pending flag of each core |
| pend_crit | output | NUM_CORES | Critical pending flag of each core |
| irq | output | NUM_CORES | Interrupt request of each core |
| core_id | output | NUM_CORES*TAG_W | Identity registers, core i at bits [i*TAG_W +: TAG_W] |

## Verification
The hardest situation to reach from the ports is a send and a clear that collide on the same flag of the same core in one cycle. It only counts when the flag starts out clear, so the bench first empties the flag with an earlier clear and then drives both requests together. A second step sets one core's critical flag while a clear drops a different core's critical flag, so both outcomes appear in the same cycle. Tag matching on several cores at once needs identity registers with equal values. The bench rewrites one core's identity to equal another's, then sends an addressed message to that shared value.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_NORMAL  = 3'd0,
        KIND_CRIT    = 3'd1,
        KIND_GUEST_N = 3'd2,
        KIND_GUEST_C = 3'd3,
        KIND_GUEST_M = 3'd4
    } dbr_kind_e;
endpackage

// File: rtl/dbr_kind_dec.sv
module dbr_kind_dec
    import dbr_pkg::*;
(
    input  logic              valid,
    input  logic [KIND_W-1:0] kind,
    output logic              is_norm,
    output logic              is_crit
);
    always_comb begin
        is_norm = 1'b0;
        is_crit = 1'b0;
        if (valid) begin
            unique case (kind)
                KIND_NORMAL: is_norm = 1'b1;
                KIND_CRIT:   is_crit = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        assert_onehot_kind_R1: assert ($onehot0({is_norm, is_crit}));
    end
endmodule

// File: rtl/dbr_core_slot.sv
module dbr_core_slot #(
    parameter int TAG_W    = 8,
    parameter int RESET_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_norm,
    input  logic             set_crit,
    input  logic             drop_norm,
    input  logic             drop_crit,
    input  logic             id_we,
    input  logic [TAG_W-1:0] id_wdata,
    output logic [TAG_W-1:0] id,
    output logic             pn,
    output logic             pc
);
    typedef struct packed {
        logic [TAG_W-1:0] id;
        logic             pn;
        logic             pc;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (id_we)     st_d.id = id_wdata;
        if (drop_norm) st_d.pn = 1'b0;
        if (drop_crit) st_d.pc = 1'b0;
        if (set_norm)  st_d.pn = 1'b1;
        if (set_crit)  st_d.pc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.id <= TAG_W'(RESET_ID);
            st_q.pn <= 1'b0;
            st_q.pc <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign id = st_q.id;
    assign pn = st_q.pn;
    assign pc = st_q.pc;

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_norm || set_crit) |=> ((pn || !$past(set_norm)) && (pc || !$past(set_crit))));

    assert_drop_norm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_norm && !set_norm) |=> !pn);

    assert_drop_crit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_crit && !set_crit) |=> !pc);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_norm && !drop_norm && !set_crit && !drop_crit) |=> ($stable(pn) && $stable(pc)));

    assert_id_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !id_we |=> $stable(id));
endmodule

// File: rtl/dbell_router.sv
module dbell_router
    import dbr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TAG_W     = 8,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int MSG_W    = TAG_W + 1 + KIND_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snd_valid,
    input  logic [MSG_W-1:0]           snd_msg,
    input  logic                       clr_valid,
    input  logic [IDX_W-1:0]           clr_src,
    input  logic [KIND_W-1:0]          clr_kind,
    input  logic [NUM_CORES-1:0]       id_we,
    input  logic [TAG_W-1:0]           id_wdata,
    output logic [NUM_CORES-1:0]       pend_norm,
    output logic [NUM_CORES-1:0]       pend_crit,
    output logic [NUM_CORES-1:0]       irq,
    output logic [NUM_CORES*TAG_W-1:0] core_id
);
    localparam int BC_BIT = TAG_W;

    logic [TAG_W-1:0]  msg_tag;
    logic              msg_bcast;
    logic [KIND_W-1:0] msg_kind;
    logic snd_norm, snd_crit, clr_norm, clr_crit;

    assign msg_tag   = snd_msg[TAG_W-1:0];
    assign msg_bcast = snd_msg[BC_BIT];
    assign msg_kind  = snd_msg[MSG_W-1:BC_BIT+1];

    dbr_kind_dec u_snd_dec (
        .valid  (snd_valid),
        .kind   (msg_kind),
        .is_norm(snd_norm),
        .is_crit(snd_crit)
    );

    dbr_kind_dec u_clr_dec (
        .valid  (clr_valid),
        .kind   (clr_kind),
        .is_norm(clr_norm),
        .is_crit(clr_crit)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        logic [TAG_W-1:0] id_i;
        logic             hit;
        logic             own;

        assign hit = msg_bcast || (msg_tag == id_i);
        assign own = (clr_src == IDX_W'(i));

        dbr_core_slot #(
            .TAG_W   (TAG_W),
            .RESET_ID(i)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_norm (snd_norm && hit),
            .set_crit (snd_crit && hit),
            .drop_norm(clr_norm && own),
            .drop_crit(clr_crit && own),
            .id_we    (id_we[i]),
            .id_wdata (id_wdata),
            .id       (id_i),
            .pn       (pend_norm[i]),
            .pc       (pend_crit[i])
        );

        assign core_id[i*TAG_W +: TAG_W] = id_i;
        assign irq[i] = pend_norm[i] | pend_crit[i];
    end

    assert_ignored_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && msg_kind > 3'd1 && !clr_valid) |=> ($stable(pend_norm) && $stable(pend_crit)));

    assert_bcast_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && msg_bcast && msg_kind == 3'd1) |=> (&pend_crit));

    assert_bad_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && clr_kind > 3'd1 && !snd_valid) |=> ($stable(pend_norm) && $stable(pend_crit)));

    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_crit[0]) |-> irq[0]);
endmodule

// File: tb/sim_dbell_router.sv
module sim_dbell_router;
    localparam int N   = 4;
    localparam int TW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snd_valid = 1'b0;
    logic [TW+3:0] snd_msg = '0;
    logic          clr_valid = 1'b0;
    logic [1:0]    clr_src = '0;
    logic [2:0]    clr_kind = '0;
    logic [N-1:0]  id_we = '0;
    logic [TW-1:0] id_wdata = '0;
    logic [N-1:0]  pend_norm, pend_crit, irq;
    logic [N*TW-1:0] core_id;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    dbell_router #(.NUM_CORES(N), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_msg(snd_msg),
        .clr_valid(clr_valid), .clr_src(clr_src), .clr_kind(clr_kind),
        .id_we(id_we), .id_wdata(id_wdata), .pend_norm(pend_norm),
        .pend_crit(pend_crit), .irq(irq), .core_id(core_id)
    );

    typedef struct packed {
        logic          sv;
        logic [2:0]    sk;
        logic          sb;
        logic [TW-1:0] st;
        logic          cv;
        logic [1:0]    cs;
        logic [2:0]    ck;
        logic [N-1:0]  en;
        logic [N-1:0]  ec;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{1'b1, 3'd0, 1'b0, 8'd2, 1'b0, 2'd0, 3'd0, 4'b0100, 4'b0000},
        '{1'b1, 3'd1, 1'b1, 8'd7, 1'b0, 2'd0, 3'd0, 4'b0100, 4'b1111},
        '{1'b1, 3'd3, 1'b1, 8'd0, 1'b0, 2'd0, 3'd0, 4'b0100, 4'b1111},
        '{1'b0, 3'd0, 1'b0, 8'd0, 1'b1, 2'd2, 3'd0, 4'b0000, 4'b1111},
        '{1'b0, 3'd0, 1'b0, 8'd0, 1'b1, 2'd1, 3'd1, 4'b0000, 4'b1101},
        '{1'b0, 3'd0, 1'b0, 8'd0, 1'b1, 2'd0, 3'd5, 4'b0000, 4'b1101},
        '{1'b1, 3'd0, 1'b0, 8'd9, 1'b0, 2'd0, 3'd0, 4'b0000, 4'b1101},
        '{1'b1, 3'd0, 1'b0, 8'd1, 1'b1, 2'd1, 3'd0, 4'b0010, 4'b1101},
        '{1'b1, 3'd1, 1'b0, 8'd1, 1'b1, 2'd3, 3'd1, 4'b0010, 4'b0111},
        '{1'b1, 3'd0, 1'b1, 8'd3, 1'b0, 2'd0, 3'd0, 4'b1111, 4'b0111},
        '{1'b1, 3'd4, 1'b0, 8'd0, 1'b0, 2'd0, 3'd0, 4'b1111, 4'b0111},
        '{1'b0, 3'd0, 1'b0, 8'd0, 1'b1, 2'd3, 3'd0, 4'b0111, 4'b0111}
    };

    localparam string VREQ [NV] = '{
        "R4", "R3", "R2", "R6", "R6", "R7", "R4", "R8", "R8", "R3", "R2", "R10"
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        snd_valid = v.sv;
        snd_msg   = {v.sk, v.sb, v.st};
        clr_valid = v.cv;
        clr_src   = v.cs;
        clr_kind  = v.ck;
        @(negedge clk);
        snd_valid = 1'b0;
        clr_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R10 and R9: reset state
        check("R10", {28'd0, pend_norm}, 32'd0);
        check("R10", {28'd0, pend_crit}, 32'd0);
        check("R9", core_id, 32'h03020100);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            apply(VT[k]);
            check(VREQ[k], {28'd0, pend_norm}, {28'd0, VT[k].en});
            check(VREQ[k], {28'd0, pend_crit}, {28'd0, VT[k].ec});
            check("R5", {28'd0, irq}, {28'd0, VT[k].en | VT[k].ec});
        end

        // R1: field layout, kind 1 addressed to core 0 only
        v = '{1'b0, 3'd0, 1'b0, 8'd0, 1'b1, 2'd0, 3'd1, 4'b0111, 4'b0110};
        apply(v);
        check("R6", {28'd0, pend_crit}, 32'h6);
        v = '{1'b1, 3'd1, 1'b0, 8'd0, 1'b0, 2'd0, 3'd0, 4'b0, 4'b0};
        apply(v);
        check("R1", {28'd0, pend_crit}, 32'h7);
        check("R1", {28'd0, pend_norm}, 32'h7);

        // R9: reset restores IDs, a write retargets later sends
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", {28'd0, irq}, 32'd0);
        rst_n = 1'b1;
        id_we = 4'b1000;
        id_wdata = 8'd2;
        @(negedge clk);
        id_we = '0;
        check("R9", core_id, 32'h02020100);
        v = '{1'b1, 3'd0, 1'b0, 8'd2, 1'b0, 2'd0, 3'd0, 4'b0, 4'b0};
        apply(v);
        check("R9", {28'd0, pend_norm}, 32'hC);
        check("R4", {28'd0, pend_crit}, 32'h0);
        v = '{1'b1, 3'd0, 1'b0, 8'd3, 1'b0, 2'd0, 3'd0, 4'b0, 4'b0};
        apply(v);
        check("R4", {28'd0, pend_norm}, 32'hC);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule